// File: doc/BRIEF.md
# Ratiometric ADC Conversion Controller

This block is the digital control side of a sampled analog-to-digital front end. A 32-bit word-wide register bus reaches two registers: a control word and a result word. Software sets an input channel, a reference choice, a clock divider, an enable and an interrupt enable. It then sets the conversion bit. A prescaled timer running from the module clock sets how long the conversion lasts. When the timer expires, the selected channel's digital sample is scaled against the chosen reference into a saturated 10-bit code. The busy bit then drops, and an interrupt is raised if it is enabled.

At the start of a conversion, the controller captures the channel index, the sample and the reference. A serial divider then works out the code while the timer runs, and the code is committed at expiry. Both registers, and any conversion in progress, can be reset by setting one bit in a control write. The interrupt flag is cleared by writing a one to it. The interrupt line is a registered level. A completion sets it, and a write-one clear or any reset drops it.

Top module: `adc_ctrl_top`

## Requirements
- R1: After reset the control register reads 0x000C0001, the result register reads 0 and irq is low.
- R2: Word address 0 selects control and word address 1 selects the result. Writes to address 1 change nothing, and reads of any other address return 0. Read data appears on bus_rdata one cycle after bus_rd.
- R3: A conversion commits exactly 20 × 2 × (divider + 1) clock cycles after the write that starts it. The divider is control bits 8:1.
- R4: The committed result is floor(sample × 1024 / reference), clamped to 1023. A zero reference gives 1023. Control bit 19 = 1 selects int_ref, and 0 selects ext_ref. Bits 27:24 pick the channel.
- R5: On completion, control bit 14 (busy/start) clears. If bit 21 (interrupt enable) is set, bit 18 (flag) is set and irq rises; otherwise neither changes.
- R6: Writing a control word with bit 18 = 1 clears the flag and drops irq. Writing it with bit 18 = 0 keeps the current flag and irq.
- R7: A control write with bit 16 set puts both registers in their R1 state, drops irq and cancels any running conversion.
- R8: With bit 17 (enable) set in the written word, a 0-to-1 change of bit 14 starts a conversion. Writing bit 14 = 0 cancels a pending conversion.
- R9: A conversion started with a channel index of 8 or more changes neither the result, the flag, irq, nor bit 14.
- R10: If a control write lands in the completion cycle, the completion is applied first and the write second. A start bit in that write begins a new conversion.
- R11: Setting bit 14 while bit 17 is 0 in the written word starts no conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| chan_samples | input | NUM_CH*SAMP_W | Packed per-channel samples, channel 0 in the low bits |
| ext_ref | input | REF_W | External reference value |
| int_ref | input | REF_W | Internal reference value |
| irq | output | 1 | Level interrupt |

## Verification
A timer expiry and a software write to the control register can fall in the same clock cycle. The bench sets this up by counting exactly 20 × prescaler − 1 edges after a start, then issuing a control write that lands on the completion edge. One such write starts a second conversion without the clear bit, and another carries only the write-one clear. In the first case the bench expects the first code to be committed, irq to be high and the second conversion's code to follow one interval later. In the second case it expects irq to be low even though the completion set it in that same cycle.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  localparam int WORD_W    = 32;
  localparam int CH_LSB    = 24;
  localparam int CH_W      = 4;
  localparam int B_IE      = 21;
  localparam int B_REFSEL  = 19;
  localparam int B_FLAG    = 18;
  localparam int B_EN      = 17;
  localparam int B_SRST    = 16;
  localparam int B_CONV    = 14;
  localparam int DIV_LSB   = 1;
  localparam int DIV_W     = 8;
  localparam int CODE_W    = 10;
  localparam int CODE_MAX  = (1 << CODE_W) - 1;
  localparam logic [WORD_W-1:0] CTRL_RESET = 32'h000C_0001;
endpackage

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int CONV_CYCLES = 20,
  parameter int DIV_W       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  input  logic [DIV_W-1:0] div,
  output logic             expire
);
  localparam int MAX_TICKS = CONV_CYCLES * 2 * (1 << DIV_W);
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic [CNT_W-1:0] presc;
  logic [CNT_W-1:0] load;

  always_comb begin
    presc = CNT_W'({1'b0, div}) + CNT_W'(1);
    presc = presc << 1;
    load  = CNT_W'(CONV_CYCLES) * presc - CNT_W'(1);
  end

  assign expire = run_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= load;
    end else if (stop || expire) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/adc_divider.sv
module adc_divider #(
  parameter int DVD_W = 34,
  parameter int DVS_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic [DVD_W-1:0] quotient
);
  localparam int CNT_W = $clog2(DVD_W + 1);

  logic [DVD_W-1:0] quo_q;
  logic [DVS_W-1:0] rem_q;
  logic [DVS_W-1:0] dvs_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DVS_W:0]   trial;
  logic [DVS_W:0]   diff;
  logic             fits;

  always_comb begin
    trial = {rem_q, quo_q[DVD_W-1]};
    diff  = trial - {1'b0, dvs_q};
    fits  = trial >= {1'b0, dvs_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quo_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
    end else if (start) begin
      quo_q <= dividend;
      rem_q <= '0;
      dvs_q <= divisor;
      cnt_q <= CNT_W'(DVD_W);
    end else if (cnt_q != '0) begin
      quo_q <= {quo_q[DVD_W-2:0], fits};
      rem_q <= fits ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign quotient = quo_q;
endmodule

// File: rtl/adc_ctrl_top.sv
module adc_ctrl_top
  import adc_ctrl_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int SAMP_W      = 24,
  parameter int REF_W       = 24,
  parameter int ADDR_W      = 10,
  parameter int CONV_CYCLES = 20
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic [NUM_CH*SAMP_W-1:0] chan_samples,
  input  logic [REF_W-1:0]         ext_ref,
  input  logic [REF_W-1:0]         int_ref,
  output logic                     irq
);
  localparam int DVD_W = SAMP_W + CODE_W;

  logic [WORD_W-1:0] con_q, con_mid, con_n, wr_word;
  logic [CODE_W-1:0] data_q, data_n, code;
  logic              irq_q, irq_n;
  logic              cap_ok_q;
  logic              ctrl_wr;
  logic              t_start, t_stop, tmr_expire;
  logic [CH_W-1:0]   new_ch;
  logic [SAMP_W-1:0] sel_sample;
  logic [REF_W-1:0]  sel_ref;
  logic [DVD_W-1:0]  quotient;

  assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(0));
  assign new_ch  = wr_word[CH_LSB +: CH_W];

  // channel mux for the word being written (captured only on a start)
  always_comb begin
    sel_sample = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (new_ch == CH_W'(i)) sel_sample = chan_samples[i*SAMP_W +: SAMP_W];
    end
    sel_ref = wr_word[B_REFSEL] ? int_ref : ext_ref;
  end

  // saturation of the divider output
  assign code = (quotient > DVD_W'(CODE_MAX)) ? CODE_W'(CODE_MAX) : quotient[CODE_W-1:0];

  // completion is applied first, then a control write on top of it
  always_comb begin
    con_mid = con_q;
    data_n  = data_q;
    irq_n   = irq_q;
    t_start = 1'b0;
    t_stop  = 1'b0;
    if (tmr_expire && cap_ok_q) begin
      data_n          = code;
      con_mid[B_CONV] = 1'b0;
      if (con_q[B_IE]) begin
        con_mid[B_FLAG] = 1'b1;
        irq_n           = 1'b1;
      end
    end
    con_n   = con_mid;
    wr_word = bus_wdata;
    if (ctrl_wr) begin
      if (bus_wdata[B_FLAG]) begin
        wr_word[B_FLAG] = 1'b0;
        irq_n           = 1'b0;
      end else begin
        wr_word[B_FLAG] = con_mid[B_FLAG];
      end
      if (wr_word[B_SRST]) begin
        con_n  = CTRL_RESET;
        data_n = '0;
        irq_n  = 1'b0;
        t_stop = 1'b1;
      end else begin
        con_n = wr_word;
        if (wr_word[B_EN]) begin
          if (wr_word[B_CONV]) t_start = !con_mid[B_CONV];
          else                 t_stop  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      con_q    <= CTRL_RESET;
      data_q   <= '0;
      irq_q    <= 1'b0;
      cap_ok_q <= 1'b0;
    end else begin
      con_q  <= con_n;
      data_q <= data_n;
      irq_q  <= irq_n;
      if (t_start) cap_ok_q <= (32'(new_ch) < NUM_CH);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (bus_addr == ADDR_W'(0))      bus_rdata <= con_q;
      else if (bus_addr == ADDR_W'(1)) bus_rdata <= 32'(data_q);
      else                             bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
    end
  end

  assign irq = irq_q;

  adc_conv_timer #(
    .CONV_CYCLES(CONV_CYCLES),
    .DIV_W      (DIV_W)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (t_start),
    .stop  (t_stop),
    .div   (wr_word[DIV_LSB +: DIV_W]),
    .expire(tmr_expire)
  );

  adc_divider #(
    .DVD_W(DVD_W),
    .DVS_W(REF_W)
  ) u_div (
    .clk     (clk),
    .rst     (rst),
    .start   (t_start),
    .dividend({sel_sample, CODE_W'(0)}),
    .divisor (sel_ref),
    .quotient(quotient)
  );
endmodule

// File: rtl/adc_ctrl_checker.sv
module adc_ctrl_checker
  import adc_ctrl_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              irq,
  input logic [WORD_W-1:0] con_q,
  input logic [CODE_W-1:0] data_q,
  input logic              tmr_expire,
  input logic              cap_ok_q
);
  logic ctrl_wr;
  assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(0));

  AST_W1C_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && bus_wdata[B_FLAG]) |=> !irq); // R6

  AST_SOFT_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && bus_wdata[B_SRST]) |=> (con_q == CTRL_RESET && data_q == '0 && !irq)); // R7

  AST_BUSY_CLEARS_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    (tmr_expire && cap_ok_q && !ctrl_wr) |=> !con_q[B_CONV]); // R5

  AST_IRQ_RISES_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(tmr_expire)); // R5

  AST_BAD_CHANNEL_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (tmr_expire && !cap_ok_q && !ctrl_wr) |=> ($stable(data_q) && $stable(irq))); // R9

  AST_RESULT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(1) && !tmr_expire) |=> $stable(data_q)); // R2
endmodule

bind adc_ctrl_top adc_ctrl_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq       (irq),
  .con_q     (con_q),
  .data_q    (data_q),
  .tmr_expire(tmr_expire),
  .cap_ok_q  (cap_ok_q)
);

// File: tb/adc_ctrl_top_test.sv
`timescale 1ns/1ps
module adc_ctrl_top_test;
  localparam int NUM_CH = 8;
  localparam int SAMP_W = 24;
  localparam int REF_W  = 24;
  localparam int ADDR_W = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                     rst, bus_wr, bus_rd, irq;
  logic [ADDR_W-1:0]        bus_addr;
  logic [31:0]              bus_wdata, bus_rdata;
  logic [NUM_CH*SAMP_W-1:0] chan_samples;
  logic [REF_W-1:0]         ext_ref, int_ref;
  logic [SAMP_W-1:0]        samp [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_pack
    assign chan_samples[g*SAMP_W +: SAMP_W] = samp[g];
  end

  adc_ctrl_top uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chan_samples(chan_samples),
    .ext_ref(ext_ref), .int_ref(int_ref), .irq(irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] rv, last_data, code_a, code_b;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    v = bus_rdata;
    bus_rd = 1'b0;
  endtask

  function automatic logic [31:0] ctl(int ch, bit ie, bit rs, bit en, bit cv, int dv, bit w1c);
    logic [31:0] w = '0;
    w[27:24] = ch[3:0]; w[21] = ie; w[19] = rs; w[18] = w1c;
    w[17] = en; w[14] = cv; w[8:1] = dv[7:0];
    return w;
  endfunction

  function automatic logic [31:0] exp_code(logic [SAMP_W-1:0] s, logic [REF_W-1:0] r);
    logic [63:0] q;
    if (r == '0) return 32'd1023;
    q = ({40'd0, s} * 64'd1024) / {40'd0, r};
    return (q > 64'd1023) ? 32'd1023 : q[31:0];
  endfunction

  // waits for the commit edge of a conversion started by the last write
  task automatic expect_commit(int p, string req);
    repeat (20*p - 1) @(posedge clk);
    #1 chk(req, 32'(irq), 32'd0);
    @(posedge clk); #1;
    chk(req, 32'(irq), 32'd1);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    for (int i = 0; i < NUM_CH; i++) samp[i] = 24'(100000 * (i + 1) + 777);
    ext_ref = 24'd3_000_000;
    int_ref = 24'd2_000_000;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    #1 chk("R1 irq", 32'(irq), 32'd0);
    rd(0, rv); chk("R1 ctrl", rv, 32'h000C_0001);
    rd(1, rv); chk("R1 data", rv, 32'd0);
    rd(5, rv); chk("R2 unknown addr", rv, 32'd0);

    // R3 R4 R5 basic conversion, ext ref, flag preserved from reset
    wr(0, ctl(2, 1, 0, 1, 1, 0, 0));
    expect_commit(2, "R3 timing div0");
    rd(1, rv); chk("R4 ext ref code", rv, exp_code(samp[2], ext_ref));
    last_data = rv;
    rd(0, rv); chk("R5 busy clear flag set", rv & 32'h0004_4000, 32'h0004_0000);

    // R6 write zero keeps flag, write one clears
    wr(0, ctl(2, 1, 0, 1, 0, 0, 0));
    chk("R6 keep irq", 32'(irq), 32'd1);
    rd(0, rv); chk("R6 keep flag", rv & 32'h0004_0000, 32'h0004_0000);
    wr(0, ctl(2, 1, 0, 1, 0, 0, 1));
    chk("R6 clear irq", 32'(irq), 32'd0);
    rd(0, rv); chk("R6 clear flag", rv & 32'h0004_0000, 32'd0);

    // R2 result write ignored
    wr(1, 32'h0000_03A5);
    rd(1, rv); chk("R2 data write ignored", rv, last_data);

    // R3 longer prescaler, R4 internal ref
    wr(0, ctl(5, 1, 1, 1, 1, 3, 1));
    expect_commit(8, "R3 timing div3");
    rd(1, rv); chk("R4 int ref code", rv, exp_code(samp[5], int_ref));
    last_data = rv;

    // R5 completion without interrupt enable
    samp[0] = 24'hFFFFFF; ext_ref = 24'd1000;
    wr(0, ctl(0, 0, 0, 1, 1, 0, 1));
    repeat (45) @(posedge clk); #1;
    chk("R5 no irq without enable", 32'(irq), 32'd0);
    rd(0, rv); chk("R5 no flag without enable", rv & 32'h0004_4000, 32'd0);
    rd(1, rv); chk("R4 saturate", rv, 32'd1023);

    // R4 zero reference
    ext_ref = '0; samp[1] = 24'd5;
    wr(0, ctl(1, 0, 0, 1, 1, 0, 0));
    repeat (45) @(posedge clk);
    rd(1, rv); chk("R4 zero ref", rv, 32'd1023);
    ext_ref = 24'd3_000_000;
    last_data = rv;

    // R8 abort
    wr(0, ctl(3, 1, 0, 1, 1, 0, 1));
    repeat (10) @(posedge clk);
    wr(0, ctl(3, 1, 0, 1, 0, 0, 0));
    repeat (60) @(posedge clk); #1;
    chk("R8 abort irq", 32'(irq), 32'd0);
    rd(1, rv); chk("R8 abort data", rv, last_data);

    // R11 start with enable low
    wr(0, ctl(4, 1, 0, 0, 1, 0, 0));
    repeat (60) @(posedge clk); #1;
    chk("R11 no start irq", 32'(irq), 32'd0);
    rd(1, rv); chk("R11 no start data", rv, last_data);
    wr(0, ctl(4, 1, 0, 1, 0, 0, 0));

    // R9 invalid channel
    wr(0, ctl(9, 1, 0, 1, 1, 0, 0));
    repeat (60) @(posedge clk); #1;
    chk("R9 bad channel irq", 32'(irq), 32'd0);
    rd(1, rv); chk("R9 bad channel data", rv, last_data);
    rd(0, rv); chk("R9 busy stays", rv & 32'h0004_4000, 32'h0000_4000);
    wr(0, ctl(0, 1, 0, 1, 0, 0, 0));

    // R7 soft reset during conversion
    wr(0, ctl(6, 1, 0, 1, 1, 0, 0));
    repeat (5) @(posedge clk);
    wr(0, 32'h0001_0000);
    chk("R7 irq", 32'(irq), 32'd0);
    rd(0, rv); chk("R7 ctrl", rv, 32'h000C_0001);
    rd(1, rv); chk("R7 data", rv, 32'd0);
    repeat (60) @(posedge clk); #1;
    chk("R7 cancelled", 32'(irq), 32'd0);

    // R10 write on completion edge that restarts
    code_a = exp_code(samp[1], ext_ref);
    code_b = exp_code(samp[7], ext_ref);
    wr(0, ctl(1, 1, 0, 1, 1, 0, 1));
    repeat (39) @(posedge clk); #1;
    wr(0, ctl(7, 1, 0, 1, 1, 0, 0));
    chk("R10 irq after collision", 32'(irq), 32'd1);
    rd(1, rv); chk("R10 first code", rv, code_a);
    rd(0, rv); chk("R10 restart busy", rv & 32'h0000_4000, 32'h0000_4000);
    repeat (50) @(posedge clk);
    rd(1, rv); chk("R10 second code", rv, code_b);

    // R10 write-one clear on completion edge
    wr(0, ctl(2, 1, 0, 1, 1, 0, 1));
    repeat (39) @(posedge clk); #1;
    wr(0, ctl(2, 1, 0, 1, 0, 0, 1));
    chk("R10 clear wins", 32'(irq), 32'd0);
    rd(1, rv); chk("R10 code kept", rv, exp_code(samp[2], ext_ref));

    // random conversions R3 R4
    for (int it = 0; it < 30; it++) begin
      int ch, dv;
      bit rs;
      logic [31:0] e;
      ch = int'($urandom % NUM_CH);
      dv = int'($urandom % 4);
      rs = 1'($urandom % 2);
      samp[ch] = 24'($urandom);
      if ($urandom % 4 == 0) ext_ref = 24'($urandom % 3000);
      else ext_ref = 24'($urandom);
      if ($urandom % 4 == 0) int_ref = 24'($urandom % 3000);
      else int_ref = 24'($urandom);
      e = exp_code(samp[ch], rs ? int_ref : ext_ref);
      wr(0, ctl(ch, 1, rs, 1, 1, dv, 1));
      expect_commit(2 * (dv + 1), "R3 random timing");
      rd(1, rv); chk("R4 random code", rv, e);
    end

    finish_run();
  end
endmodule